// File: doc/BRIEF.md
# In-Order Issue Scoreboard with Write-Back Slot Reservation

This block is the issue gate of an in-order pipeline whose execution units finish after different numbers of cycles. Each cycle it receives one decoded instruction: the unit class it needs, a destination register and two source registers. In the same cycle it decides whether that instruction may leave the issue stage. Operand values are captured when an instruction issues, so only pending writes are tracked. A per-register pending-write vector catches read-after-write and write-after-write hazards. A busy flag on the unpipelined divider prevents a second divide while one is in flight. A shift register of reserved future write-back cycles keeps the single write port from being claimed twice in the same cycle.

Inside the block, each unit is modelled as a chain of stages. Every stage carries a valid flag and a destination register number. The last stage of each chain drives the write-back port, and the same event clears the pending bit. No arithmetic or data values pass through the block.

Top module: `sb_issue_ctl`

## Requirements
- R1: After synchronous reset, `pend_o` is all zero, `wb_en_o` is low, and `dispatch_o` is low while `in_valid` is low.
- R2: `in_unit` encodes the unit class as 0 integer, 1 add, 2 multiply and 3 divide, with latencies of 1, 1, 3 and 4 cycles. An instruction dispatched in cycle c shows `wb_en_o` high with `wb_reg_o` equal to its destination in cycle c+L, where L is its latency.
- R3: The `pend_o` bit of a dispatched destination is set from the cycle after dispatch through its write-back cycle. It is clear in the following cycle.
- R4: An instruction whose source register has a pending write that does not clear in the current cycle is held with `dispatch_o` low.
- R5: An instruction whose destination has a pending write that does not clear in the current cycle is held, so a register is the destination of at most one in-flight instruction.
- R6: The divider takes a new divide no earlier than 4 cycles after the previous divide was dispatched. The integer, add and multiply units accept a new instruction every cycle.
- R7: An instruction of latency L in cycle c is held if another in-flight instruction writes back in cycle c+L. At most one write-back occurs per cycle.
- R8: A pending bit that clears in cycle c does not block a read or a write of that register by an instruction offered in cycle c.
- R9: There is no write-after-read check: an instruction may write a register that an in-flight instruction reads.
- R10: While `in_valid` is low, `dispatch_o` is low and `pend_o` does not change, whatever the other instruction inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_unit | input | 2 | Unit class of the offered instruction |
| in_dest | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| dispatch_o | output | 1 | The offered instruction issues at this clock edge |
| wb_en_o | output | 1 | A write-back happens this cycle |
| wb_reg_o | output | 5 | Register written back this cycle |
| pend_o | output | 32 | Pending-write vector, one bit per register |

## Verification
`dispatch_o` is a same-cycle answer, so it is compared a short delay after the inputs change at the falling edge, before the rising edge that would take the instruction. Write-back is due exactly L rising edges after dispatch. The monitor looks for it in that cycle by due-cycle number, because out-of-order completion means it is not necessarily the oldest one. A pending bit is expected one edge after dispatch and is expected to stay through the write-back cycle, so the vector check leaves out items issued in the current cycle. Stall lengths are derived from these due cycles and compared as cycle gaps between dispatches.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  // Unit class codes carried on in_unit
  typedef enum logic [1:0] {
    U_INT = 2'd0,
    U_ADD = 2'd1,
    U_MUL = 2'd2,
    U_DIV = 2'd3
  } unit_e;

  localparam int NUM_UNITS = 4;
endpackage

// File: rtl/sb_unit_pipe.sv
`timescale 1ns/1ps
// Chain of stages for one execution unit; each stage holds a valid flag and a
// destination register. The last stage presents the write-back request.
module sb_unit_pipe #(
  parameter int DEPTH     = 3,
  parameter bit PIPELINED = 1'b1,
  parameter int RW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [RW-1:0] dest,
  output logic          busy,
  output logic          wb_vld,
  output logic [RW-1:0] wb_reg
);
  logic [DEPTH-1:0]         vld_q;
  logic [DEPTH-1:0][RW-1:0] reg_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= accept;
        reg_q[0] <= dest;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[DEPTH-2:0], accept};
        reg_q <= {reg_q[DEPTH-2:0], dest};
      end
    end

    // An unpipelined unit is busy while its op sits in any stage but the last;
    // in the last stage it leaves at this edge and a new op may enter.
    if (PIPELINED || DEPTH == 1) begin : g_free
      assign busy = 1'b0;
    end else begin : g_hold
      assign busy = |vld_q[DEPTH-2:0];
    end
  endgenerate

  assign wb_vld = vld_q[DEPTH-1];
  assign wb_reg = reg_q[DEPTH-1];

  generate
    if (!PIPELINED) begin : g_chk
      assert_unpipelined_single_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(vld_q) <= 1);
    end
  endgenerate
endmodule

// File: rtl/sb_wb_slots.sv
`timescale 1ns/1ps
// Reservation shift register: bit k set means a write-back is booked k cycles
// from now. Bit 0 therefore marks this cycle's write-back.
module sb_wb_slots #(
  parameter int MAXL = 4,
  parameter int LW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [LW-1:0] lat,
  output logic [MAXL:0] resv
);
  logic [MAXL:0] resv_d;

  always_comb begin
    resv_d = '0;
    for (int k = 0; k < MAXL; k++) begin
      resv_d[k] = resv[k+1] | (fire && (lat == LW'(k + 1)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) resv <= '0;
    else     resv <= resv_d;
  end

  assert_slot_free_R7: assert property (@(posedge clk) disable iff (rst)
    fire |-> !resv[lat]);
endmodule

// File: rtl/sb_pending.sv
`timescale 1ns/1ps
// Pending-write vector. The clear from write-back is applied ahead of the
// hazard view, so a register freed this cycle is usable this cycle.
module sb_pending #(
  parameter int NREGS = 32,
  parameter int RW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [RW-1:0]    set_reg,
  input  logic             clr_en,
  input  logic [RW-1:0]    clr_reg,
  output logic [NREGS-1:0] pend_q,
  output logic [NREGS-1:0] pend_eff
);
  localparam logic [NREGS-1:0] ONE = {{(NREGS-1){1'b0}}, 1'b1};

  logic [NREGS-1:0] clr_mask, set_mask;

  assign clr_mask = clr_en ? (ONE << clr_reg) : '0;
  assign set_mask = set_en ? (ONE << set_reg) : '0;
  assign pend_eff = pend_q & ~clr_mask;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_eff | set_mask;
  end

  assert_set_visible_R3: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_q[$past(set_reg)]);

  assert_clear_applied_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_reg == clr_reg)) |=> !pend_q[$past(clr_reg)]);
endmodule

// File: rtl/sb_issue_ctl.sv
`timescale 1ns/1ps
module sb_issue_ctl #(
  parameter int NREGS         = 32,
  parameter int LAT_INT       = 1,
  parameter int LAT_ADD       = 1,
  parameter int LAT_MUL       = 3,
  parameter int LAT_DIV       = 4,
  parameter bit DIV_PIPELINED = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [1:0]               in_unit,
  input  logic [$clog2(NREGS)-1:0] in_dest,
  input  logic [$clog2(NREGS)-1:0] in_src1,
  input  logic [$clog2(NREGS)-1:0] in_src2,
  output logic                     dispatch_o,
  output logic                     wb_en_o,
  output logic [$clog2(NREGS)-1:0] wb_reg_o,
  output logic [NREGS-1:0]         pend_o
);
  import sb_pkg::*;

  localparam int RW   = $clog2(NREGS);
  localparam int M1   = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
  localparam int M2   = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int LW   = $clog2(MAXL + 1);
  localparam int LATS  [NUM_UNITS] = '{LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV};
  localparam bit PIPED [NUM_UNITS] = '{1'b1, 1'b1, 1'b1, DIV_PIPELINED};

  logic [NUM_UNITS-1:0] unit_busy, lane_vld;
  logic [RW-1:0]        lane_reg [NUM_UNITS];
  logic [MAXL:0]        resv;
  logic [NREGS-1:0]     pend_q, pend_eff;
  logic [LW-1:0]        sel_lat;
  logic                 fire, wb_en;
  logic [RW-1:0]        wb_reg;

  always_comb begin
    unique case (unit_e'(in_unit))
      U_INT:   sel_lat = LW'(LAT_INT);
      U_ADD:   sel_lat = LW'(LAT_ADD);
      U_MUL:   sel_lat = LW'(LAT_MUL);
      default: sel_lat = LW'(LAT_DIV);
    endcase
  end

  // Issue gate: unit free, no RAW, no WAW, write-back slot free
  assign fire = in_valid && !unit_busy[in_unit]
             && !pend_eff[in_src1] && !pend_eff[in_src2]
             && !pend_eff[in_dest] && !resv[sel_lat];

  generate
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      sb_unit_pipe #(
        .DEPTH    (LATS[g]),
        .PIPELINED(PIPED[g]),
        .RW       (RW)
      ) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .accept(fire && (in_unit == 2'(g))),
        .dest  (in_dest),
        .busy  (unit_busy[g]),
        .wb_vld(lane_vld[g]),
        .wb_reg(lane_reg[g])
      );
    end
  endgenerate

  always_comb begin
    wb_reg = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (lane_vld[u]) wb_reg = wb_reg | lane_reg[u];
    end
    wb_en = |lane_vld;
  end

  sb_wb_slots #(.MAXL(MAXL), .LW(LW)) u_slots (
    .clk (clk),
    .rst (rst),
    .fire(fire),
    .lat (sel_lat),
    .resv(resv)
  );

  sb_pending #(.NREGS(NREGS), .RW(RW)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_en  (fire),
    .set_reg (in_dest),
    .clr_en  (wb_en),
    .clr_reg (wb_reg),
    .pend_q  (pend_q),
    .pend_eff(pend_eff)
  );

  assign dispatch_o = fire;
  assign wb_en_o    = wb_en;
  assign wb_reg_o   = wb_reg;
  assign pend_o     = pend_q;

  assert_one_writer_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_vld));

  assert_slot_matches_wb_R7: assert property (@(posedge clk) disable iff (rst)
    resv[0] == wb_en);

  assert_wb_was_pending_R3: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> pend_q[wb_reg]);

  assert_idle_no_fire_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !dispatch_o);
endmodule

// File: tb/sb_issue_ctl_tb_top.sv
`timescale 1ns/1ps
module sb_issue_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid;
  logic [1:0]  in_unit;
  logic [4:0]  in_dest, in_src1, in_src2;
  logic        dispatch_o, wb_en_o;
  logic [4:0]  wb_reg_o;
  logic [31:0] pend_o;

  always #10 clk = ~clk;

  sb_issue_ctl dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_dest(in_dest), .in_src1(in_src1), .in_src2(in_src2),
    .dispatch_o(dispatch_o), .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o),
    .pend_o(pend_o)
  );

  typedef struct {int due; int rg; int unit; int iss;} ent_t;
  ent_t q[$];

  int cyc;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_pend;
  int idx;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic int lat_b(int u);
    case (u)
      0: return 1;
      1: return 1;
      2: return 3;
      default: return 4;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference issue rule built from R4-style hazards, divider occupancy and slot booking
  function automatic bit model_ok(int c, int u, int d, int s1, int s2);
    bit ok = 1'b1;
    foreach (q[i]) begin
      if (q[i].due > c && (q[i].rg == s1 || q[i].rg == s2 || q[i].rg == d)) ok = 1'b0;
      if (u == 3 && q[i].unit == 3 && q[i].due > c) ok = 1'b0;
      if (q[i].due == c + lat_b(u)) ok = 1'b0;
    end
    return ok;
  endfunction

  // Driver: offers one instruction until the model says it issues
  task automatic issue(int u, int d, int s1, int s2, output int at);
    bit e;
    at = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_unit = u[1:0];
      in_dest = d[4:0]; in_src1 = s1[4:0]; in_src2 = s2[4:0];
      #2;
      e = model_ok(cyc, u, d, s1, s2);
      chk(dispatch_o == e, "R4 R5 R6 R7 dispatch decision", dispatch_o, e);
      if (e) begin
        q.push_back('{cyc + lat_b(u), d, u, cyc});
        at = cyc;
        break;
      end
    end
    if (at < 0) chk(1'b0, "R4 issue never granted", 0, 1);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pending vector and write-back against the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      #4;
      exp_pend = '0;
      foreach (q[i]) if (q[i].iss < cyc && q[i].due >= cyc) exp_pend[q[i].rg] = 1'b1;
      chk(pend_o == exp_pend, "R3 pending vector", pend_o, exp_pend);
      idx = -1;
      foreach (q[i]) if (q[i].due == cyc) idx = i;
      if (wb_en_o) begin
        if (idx < 0) chk(1'b0, "R2 unexpected writeback", wb_reg_o, 0);
        else begin
          chk(wb_reg_o == 5'(q[idx].rg), "R2 writeback register", wb_reg_o, q[idx].rg);
          q.delete(idx);
        end
      end else if (idx >= 0) begin
        chk(1'b0, "R2 missing writeback", 0, q[idx].rg);
        q.delete(idx);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a, b, c, d;
    int i1, i2, i3, i4, i5, i6;
    in_valid = 1'b0; in_unit = 2'd2; in_dest = 5'd7; in_src1 = 5'd1; in_src2 = 5'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk(dispatch_o == 1'b0, "R1 dispatch after reset", dispatch_o, 0);
    chk(wb_en_o == 1'b0, "R1 writeback after reset", wb_en_o, 0);
    chk(pend_o == 32'h0, "R1 pending after reset", pend_o, 0);
    @(negedge clk);
    #2;
    chk(pend_o == 32'h0, "R10 ignored input left pending clear", pend_o, 0);
    chk(dispatch_o == 1'b0, "R10 no dispatch while invalid", dispatch_o, 0);

    // Six-instruction mix: div, load, mul, div, sub, add
    issue(3, 6, 6, 4, i1);
    issue(0, 2, 20, 20, i2);
    issue(2, 0, 2, 4, i3);
    issue(3, 8, 6, 2, i4);
    issue(1, 10, 0, 6, i5);
    issue(1, 6, 8, 2, i6);
    chk(i2 - i1 == 1, "R2 load follows divide", i2 - i1, 1);
    chk(i3 - i1 == 2, "R8 mul reads load result in its writeback cycle", i3 - i1, 2);
    chk(i4 - i1 == 4, "R6 second divide waits for divider", i4 - i1, 4);
    chk(i5 - i1 == 5, "R4 sub waits for mul result", i5 - i1, 5);
    chk(i6 - i1 == 8, "R4 add waits for second divide", i6 - i1, 8);
    idle(8);

    issue(2, 9, 1, 1, a);
    issue(1, 15, 9, 2, b);
    chk(b - a == 3, "R4 RAW stall length", b - a, 3);
    idle(8);

    issue(2, 7, 1, 1, a);
    issue(0, 7, 2, 2, b);
    chk(b - a == 3, "R5 WAW stall length", b - a, 3);
    idle(8);

    issue(3, 16, 1, 1, a);
    issue(3, 17, 2, 2, b);
    issue(2, 18, 1, 1, c);
    issue(2, 19, 1, 1, d);
    chk(b - a == 4, "R6 divide spacing", b - a, 4);
    chk(d - c == 1, "R6 multiply accepts every cycle", d - c, 1);
    idle(8);

    issue(2, 11, 1, 1, a);
    issue(1, 12, 1, 1, b);
    issue(0, 13, 1, 1, c);
    chk(b - a == 1, "R7 add with free slot", b - a, 1);
    chk(c - a == 3, "R7 int held for writeback slot", c - a, 3);
    idle(8);

    issue(0, 5, 1, 1, a);
    issue(0, 5, 5, 5, b);
    chk(b - a == 1, "R8 clear before check", b - a, 1);
    idle(8);

    issue(3, 6, 4, 4, a);
    issue(1, 4, 2, 2, b);
    chk(b - a == 1, "R9 no WAR stall", b - a, 1);
    idle(10);

    chk(q.size() == 0, "R2 all writebacks seen", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule